// File: doc/BRIEF.md
# BCD Real-Time Calendar with Alarm

This block keeps wall-clock time and a calendar in binary-coded decimal. It advances once for each one-cycle pulse on its `tick` input, which a divider elsewhere produces once per second. It holds seconds, minutes, hours, day of week, date, month, year and century. Month lengths are applied, and February gets a 29th day in leap years. The hour field can run in a 24-hour format or in a 12-hour format with a PM bit.

Software reaches twelve byte registers through a simple register port. A write lands at the next clock edge, and the read data is combinational on the address. Four alarm registers each carry a "don't care" bit. These bits decide whether the alarm fires every second, every minute, every hour, every day or once a week.

When all enabled fields match a freshly advanced time, a sticky flag is raised. Any read or write of an alarm register clears the flag. An active-low interrupt follows the flag only while an external two-bit interval-select input is zero. Single-cycle strobes mark every advance of the seconds, minutes and hours, so that an elapsed-time counter can count in any of those units.

Top module: `rtcCalendar`

## Requirements
- R1: After reset the registers read as follows: seconds 00, minutes 00, hour 00 (24-hour), day of week 1, date 01, month 01, year 00, century 20. All alarm registers read 00. `alarmFlag`, `secStrobe`, `minStrobe` and `hourStrobe` are 0, and `alarmIntN` is 1.
- R2: The register addresses are 0 seconds, 1 minutes, 2 hour, 3 day of week, 4 date, 5 month, 6 year, 7 century, 8 alarm seconds, 9 alarm minutes, 10 alarm hour and 11 alarm day of week. Addresses 12 to 15 read 00. `rdData` shows the addressed register in the same cycle. A write with `wrEn` takes effect at the next edge. Bits that are not implemented read 0, which gives these read masks: seconds, minutes and hour 7F; day of week 07; date 3F; month 1F; year and century FF; alarm seconds, minutes and hour FF; alarm day of week 87.
- R3: Each `tick` advances the seconds by one BCD step. Seconds 59 wraps to 00 and advances the minutes. Minutes 59 wraps to 00 and advances the hour.
- R4: In 24-hour mode (hour bit 6 = 0, bits 5:0 hold 00 to 23), hour 23 wraps to 00 and advances the day.
- R5: In 12-hour mode, hour bit 6 = 1 and bit 5 is PM when set. Bits 4:0 run 12, 01, ..., 11. Each step from 11 to 12 toggles bit 5, and the step from 11 PM to 12 AM advances the day.
- R6: Each day advance moves the day of week from 1 up to 7, and 7 wraps back to 1.
- R7: The date wraps to 01 after the last day of the month and then advances the month. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the BCD year is a multiple of 4, and 28 days otherwise. All other months have 31 days. Month 12 wraps to 01 and advances the year.
- R8: Year 99 wraps to 00 and advances the century. Century 99 wraps to 00.
- R9: `secStrobe` is high for exactly one cycle, in the cycle after a `tick` cycle. That is the cycle in which the new time first reads back. `minStrobe` and `hourStrobe` pulse in that same cycle when the minutes, or the hours, advance with that tick.
- R10: Bit 7 of each alarm register masks its field. An unmasked field matches when these bits are equal to the current time: bits 6:0 for seconds, minutes and hour, and bits 2:0 for day of week. When every field matches or is masked, `alarmFlag` is set. It reads 1 in the second cycle after the `tick` cycle.
- R11: A read (`rdEn`) or write (`wrEn`) to addresses 8 to 11 clears `alarmFlag` from the next cycle on. A new match in the same cycle takes precedence over the clear. Reads of other addresses, and looking at `rdData` without `rdEn`, leave the flag unchanged.
- R12: `alarmIntN` is 0 exactly when `alarmFlag` is 1 and `intervalSel` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| regSel | input | 4 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read access strobe (used for the alarm-flag clear) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Addressed register, combinational |
| intervalSel | input | 2 | Interval select from the logger; 00 lets the interrupt through |
| alarmFlag | output | 1 | Sticky alarm flag |
| alarmIntN | output | 1 | Active-low alarm interrupt |
| secStrobe | output | 1 | Pulse on each seconds advance |
| minStrobe | output | 1 | Pulse on each minutes advance |
| hourStrobe | output | 1 | Pulse on each hours advance |

## Verification
The bench counts edges explicitly. A tick is driven for exactly one rising edge, and the advanced time and the three strobes are sampled at the falling edge straight after that edge. The alarm flag is sampled one full cycle later, and it is also checked to still be low at the earlier sample point. A register write lands one edge after it is driven, and reads are sampled one nanosecond after the address settles with no edge in between. The flag clear is checked at the falling edge following the access edge, and `alarmIntN` is checked combinationally after `intervalSel` changes.

// File: rtl/rtcPkg.sv
package rtcPkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 4;
  localparam int TIME_REGS   = 8;
  localparam int ALARM_REGS  = 4;
  localparam int ALARM_BASE  = TIME_REGS;
  localparam int REG_SLOTS   = TIME_REGS + ALARM_REGS;
  localparam int TIME_IDX_W  = $clog2(TIME_REGS);
  localparam int ALARM_IDX_W = $clog2(ALARM_REGS);

  typedef enum logic [ADDR_W-1:0] {
    ADR_SEC = 4'd0, ADR_MIN = 4'd1, ADR_HOUR = 4'd2, ADR_DOW = 4'd3,
    ADR_DATE = 4'd4, ADR_MONTH = 4'd5, ADR_YEAR = 4'd6, ADR_CENT = 4'd7
  } timeAddrT;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic                 incSec;
    logic                 incMin;
    logic                 incHour;
    logic                 incDay;
    logic                 incMonth;
    logic                 incYear;
    logic                 incCent;
    logic [REG_SLOTS-1:0] wrSel;
    logic                 alarmAccess;
    logic                 evalAlarm;
  } ctrlStrobesT;

  // Datapath-to-control "at last value" indications.
  typedef struct packed {
    logic secLast;
    logic minLast;
    logic hourLast;
    logic dateLast;
    logic monthLast;
    logic yearLast;
  } wrapFlagsT;

  function automatic logic [DATA_W-1:0] bcdInc(input logic [DATA_W-1:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // A BCD year is a multiple of four when an even tens digit meets units
  // 0/4/8, or an odd tens digit meets units 2/6.
  function automatic logic isLeap(input logic [DATA_W-1:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
    return (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
  endfunction

  function automatic logic [DATA_W-1:0] lastDay(input logic [DATA_W-1:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // 12/24-hour successor of an hour register value.
  function automatic logic [DATA_W-1:0] hourNext(input logic [DATA_W-1:0] h);
    logic [DATA_W-1:0] inc;
    if (h[6]) begin
      inc = bcdInc({3'b000, h[4:0]});
      if (h[4:0] == 5'h11)      return {2'b01, ~h[5], 5'h12};
      else if (h[4:0] == 5'h12) return {2'b01, h[5], 5'h01};
      else                      return {2'b01, h[5], inc[4:0]};
    end
    inc = bcdInc({2'b00, h[5:0]});
    if (h[5:0] == 6'h23) return '0;
    return inc;
  endfunction

  function automatic logic hourWraps(input logic [DATA_W-1:0] h);
    if (h[6]) return h[5] && (h[4:0] == 5'h11);
    return h[5:0] == 6'h23;
  endfunction

  function automatic logic [DATA_W-1:0] timeMask(input int idx);
    case (idx)
      0, 1, 2: return 8'h7F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] timeResetVal(input int idx);
    case (idx)
      3, 4, 5: return 8'h01;
      7:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] alarmMask(input int idx);
    if (idx == ALARM_REGS - 1) return 8'h87;
    return 8'hFF;
  endfunction
endpackage

// File: rtl/rtcCtrl.sv
module rtcCtrl
  import rtcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regSel,
  input  wrapFlagsT         wraps,
  output ctrlStrobesT       st,
  output logic              secStrobe,
  output logic              minStrobe,
  output logic              hourStrobe
);
  logic [REG_SLOTS-1:0] wrSelVec;
  logic incSec, incMin, incHour, incDay, incMonth, incYear, incCent;
  logic alarmHit;

  for (genvar i = 0; i < REG_SLOTS; i++) begin : gWrDecode
    assign wrSelVec[i] = wrEn && (regSel == ADDR_W'(i));
  end

  // Carry chain: each field advances when every lower field sits at its last value.
  assign incSec   = tick;
  assign incMin   = incSec   && wraps.secLast;
  assign incHour  = incMin   && wraps.minLast;
  assign incDay   = incHour  && wraps.hourLast;
  assign incMonth = incDay   && wraps.dateLast;
  assign incYear  = incMonth && wraps.monthLast;
  assign incCent  = incYear  && wraps.yearLast;

  assign alarmHit = (regSel >= ADDR_W'(ALARM_BASE)) && (regSel < ADDR_W'(REG_SLOTS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secStrobe  <= 1'b0;
      minStrobe  <= 1'b0;
      hourStrobe <= 1'b0;
    end else begin
      secStrobe  <= incSec;
      minStrobe  <= incMin;
      hourStrobe <= incHour;
    end
  end

  always_comb begin
    st.incSec      = incSec;
    st.incMin      = incMin;
    st.incHour     = incHour;
    st.incDay      = incDay;
    st.incMonth    = incMonth;
    st.incYear     = incYear;
    st.incCent     = incCent;
    st.wrSel       = wrSelVec;
    st.alarmAccess = (wrEn || rdEn) && alarmHit;
    st.evalAlarm   = secStrobe;
  end

  // R9: a coarser strobe never fires without the finer one.
  assert_strobe_chain_R9: assert property (@(posedge clk) disable iff (!rstN)
    (minStrobe |-> secStrobe) and (hourStrobe |-> minStrobe));
  // R9: strobes are single-cycle pulses for isolated ticks.
  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (secStrobe && !tick) |=> !secStrobe);
endmodule

// File: rtl/rtcDatapath.sv
module rtcDatapath
  import rtcPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobesT           st,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [TIME_IDX_W-1:0] rdIdx,
  output logic [DATA_W-1:0]     timeRd,
  output wrapFlagsT             wraps,
  output logic [DATA_W-1:0]     curSec,
  output logic [DATA_W-1:0]     curMin,
  output logic [DATA_W-1:0]     curHour,
  output logic [DATA_W-1:0]     curDow
);
  logic [TIME_REGS-1:0][DATA_W-1:0] timeReg;
  logic [TIME_REGS-1:0][DATA_W-1:0] nextVal;
  logic [TIME_REGS-1:0]             incField;
  logic                             leapYear;

  assign leapYear = isLeap(timeReg[ADR_YEAR]);

  always_comb begin
    wraps.secLast   = timeReg[ADR_SEC] == 8'h59;
    wraps.minLast   = timeReg[ADR_MIN] == 8'h59;
    wraps.hourLast  = hourWraps(timeReg[ADR_HOUR]);
    wraps.dateLast  = timeReg[ADR_DATE] == lastDay(timeReg[ADR_MONTH], leapYear);
    wraps.monthLast = timeReg[ADR_MONTH] == 8'h12;
    wraps.yearLast  = timeReg[ADR_YEAR] == 8'h99;
  end

  always_comb begin
    incField[ADR_SEC]   = st.incSec;
    incField[ADR_MIN]   = st.incMin;
    incField[ADR_HOUR]  = st.incHour;
    incField[ADR_DOW]   = st.incDay;
    incField[ADR_DATE]  = st.incDay;
    incField[ADR_MONTH] = st.incMonth;
    incField[ADR_YEAR]  = st.incYear;
    incField[ADR_CENT]  = st.incCent;
  end

  always_comb begin
    nextVal[ADR_SEC]   = wraps.secLast   ? 8'h00 : bcdInc(timeReg[ADR_SEC]);
    nextVal[ADR_MIN]   = wraps.minLast   ? 8'h00 : bcdInc(timeReg[ADR_MIN]);
    nextVal[ADR_HOUR]  = hourNext(timeReg[ADR_HOUR]);
    nextVal[ADR_DOW]   = (timeReg[ADR_DOW] >= 8'h07) ? 8'h01 : timeReg[ADR_DOW] + 8'h01;
    nextVal[ADR_DATE]  = wraps.dateLast  ? 8'h01 : bcdInc(timeReg[ADR_DATE]);
    nextVal[ADR_MONTH] = wraps.monthLast ? 8'h01 : bcdInc(timeReg[ADR_MONTH]);
    nextVal[ADR_YEAR]  = wraps.yearLast  ? 8'h00 : bcdInc(timeReg[ADR_YEAR]);
    nextVal[ADR_CENT]  = (timeReg[ADR_CENT] == 8'h99) ? 8'h00 : bcdInc(timeReg[ADR_CENT]);
  end

  // A write to a field wins over its advance in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TIME_REGS; i++) timeReg[i] <= timeResetVal(i);
    end else begin
      for (int i = 0; i < TIME_REGS; i++) begin
        if (st.wrSel[i])      timeReg[i] <= wrData & timeMask(i);
        else if (incField[i]) timeReg[i] <= nextVal[i];
      end
    end
  end

  assign timeRd  = timeReg[rdIdx];
  assign curSec  = timeReg[ADR_SEC];
  assign curMin  = timeReg[ADR_MIN];
  assign curHour = timeReg[ADR_HOUR];
  assign curDow  = timeReg[ADR_DOW];

  // R3: every tick changes the seconds register unless it is being written.
  assert_sec_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.incSec && !st.wrSel[ADR_SEC]) |=> (timeReg[ADR_SEC] != $past(timeReg[ADR_SEC])));
  // R5: a 12-hour advance never yields an hour of zero.
  assert_h12_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.incHour && !st.wrSel[ADR_HOUR] && timeReg[ADR_HOUR][6]) |=> (timeReg[ADR_HOUR][4:0] != 5'h00));
  // R6: day of week never advances to zero.
  assert_dow_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st.incDay && !st.wrSel[ADR_DOW]) |=> (timeReg[ADR_DOW] != 8'h00));
endmodule

// File: rtl/rtcAlarm.sv
module rtcAlarm
  import rtcPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobesT            st,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [ALARM_IDX_W-1:0] rdIdx,
  input  logic [DATA_W-1:0]      curSec,
  input  logic [DATA_W-1:0]      curMin,
  input  logic [DATA_W-1:0]      curHour,
  input  logic [DATA_W-1:0]      curDow,
  output logic [DATA_W-1:0]      alarmRd,
  output logic                   alarmFlag
);
  logic [ALARM_REGS-1:0][DATA_W-1:0] almReg;
  logic [ALARM_REGS-1:0][DATA_W-1:0] curField;
  logic [ALARM_REGS-1:0]             fieldHit;
  logic                              setNow;

  assign curField = {curDow, curHour, curMin, curSec};

  // A field hits when masked (bit 7) or when its value bits are equal.
  for (genvar i = 0; i < ALARM_REGS; i++) begin : gHit
    assign fieldHit[i] = almReg[i][7] || (almReg[i][6:0] == curField[i][6:0]);
  end

  assign setNow = st.evalAlarm && (&fieldHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almReg    <= '0;
      alarmFlag <= 1'b0;
    end else begin
      for (int i = 0; i < ALARM_REGS; i++)
        if (st.wrSel[ALARM_BASE + i]) almReg[i] <= wrData & alarmMask(i);
      if (setNow)               alarmFlag <= 1'b1;
      else if (st.alarmAccess)  alarmFlag <= 1'b0;
    end
  end

  assign alarmRd = almReg[rdIdx];

  // R10: the flag rises only following an evaluation cycle.
  assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(st.evalAlarm));
  // R11: an alarm-register access without a new match clears the flag.
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (st.alarmAccess && !setNow) |=> !alarmFlag);
endmodule

// File: rtl/rtcCalendar.sv
module rtcCalendar
  import rtcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [1:0]        intervalSel,
  output logic              alarmFlag,
  output logic              alarmIntN,
  output logic              secStrobe,
  output logic              minStrobe,
  output logic              hourStrobe
);
  ctrlStrobesT       st;
  wrapFlagsT         wraps;
  logic [DATA_W-1:0] timeRd, alarmRd;
  logic [DATA_W-1:0] curSec, curMin, curHour, curDow;

  rtcCtrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .regSel(regSel), .wraps(wraps), .st(st),
    .secStrobe(secStrobe), .minStrobe(minStrobe), .hourStrobe(hourStrobe)
  );

  rtcDatapath uData (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData),
    .rdIdx(regSel[TIME_IDX_W-1:0]), .timeRd(timeRd), .wraps(wraps),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDow(curDow)
  );

  rtcAlarm uAlarm (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData),
    .rdIdx(regSel[ALARM_IDX_W-1:0]),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDow(curDow),
    .alarmRd(alarmRd), .alarmFlag(alarmFlag)
  );

  always_comb begin
    if (regSel < ADDR_W'(TIME_REGS))       rdData = timeRd;
    else if (regSel < ADDR_W'(REG_SLOTS))  rdData = alarmRd;
    else                                   rdData = '0;
  end

  assign alarmIntN = !(alarmFlag && (intervalSel == 2'b00));
endmodule

// File: tb/tb_rtcCalendar.sv
`timescale 1ns/1ps
module tb_rtcCalendar;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] regSel = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [1:0] intervalSel = 2'b00;
  logic       alarmFlag, alarmIntN, secStrobe, minStrobe, hourStrobe;

  int totalCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  rtcCalendar dut (
    .clk(clk), .rstN(rstN), .tick(tick), .regSel(regSel), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .intervalSel(intervalSel),
    .alarmFlag(alarmFlag), .alarmIntN(alarmIntN), .secStrobe(secStrobe),
    .minStrobe(minStrobe), .hourStrobe(hourStrobe)
  );

  // pre/exp packed as {century, year, month, date, dow, hour, min, sec}; byte i = address i.
  typedef struct packed {
    logic [7:0]  req;
    logic [63:0] pre;
    logic [63:0] exp;
  } vecT;
  localparam int NVEC = 17;
  localparam vecT VECS [NVEC] = '{
    '{8'd3, 64'h20_00_01_01_01_00_00_00, 64'h20_00_01_01_01_00_00_01}, // R3 plain step
    '{8'd3, 64'h20_00_01_01_01_00_00_09, 64'h20_00_01_01_01_00_00_10}, // R3 BCD digit carry
    '{8'd3, 64'h20_00_01_01_01_00_05_59, 64'h20_00_01_01_01_00_06_00}, // R3 minute carry
    '{8'd4, 64'h20_00_01_01_01_09_59_59, 64'h20_00_01_01_01_10_00_00}, // R4 hour digit carry
    '{8'd8, 64'h20_99_12_31_07_23_59_59, 64'h21_00_01_01_01_00_00_00}, // R8 full roll
    '{8'd7, 64'h20_24_02_28_03_23_59_59, 64'h20_24_02_29_04_00_00_00}, // R7 leap Feb 28
    '{8'd7, 64'h20_24_02_29_04_23_59_59, 64'h20_24_03_01_05_00_00_00}, // R7 leap Feb 29
    '{8'd7, 64'h20_23_02_28_02_23_59_59, 64'h20_23_03_01_03_00_00_00}, // R7 common Feb
    '{8'd7, 64'h20_12_02_28_06_23_59_59, 64'h20_12_02_29_07_00_00_00}, // R7 odd tens leap
    '{8'd7, 64'h20_00_02_28_06_23_59_59, 64'h20_00_02_29_07_00_00_00}, // R7 year 00 leap
    '{8'd7, 64'h20_00_04_30_01_23_59_59, 64'h20_00_05_01_02_00_00_00}, // R7 30-day month
    '{8'd7, 64'h20_05_11_30_05_23_59_59, 64'h20_05_12_01_06_00_00_00}, // R7 November
    '{8'd7, 64'h20_05_10_30_01_23_59_59, 64'h20_05_10_31_02_00_00_00}, // R7 31-day month
    '{8'd5, 64'h20_00_05_10_02_51_59_59, 64'h20_00_05_10_02_72_00_00}, // R5 11AM to 12PM
    '{8'd5, 64'h20_00_05_10_03_71_59_59, 64'h20_00_05_11_04_52_00_00}, // R5 11PM to 12AM
    '{8'd5, 64'h20_00_05_10_02_72_59_59, 64'h20_00_05_10_02_61_00_00}, // R5 12PM to 1PM
    '{8'd6, 64'h99_99_12_31_07_23_59_59, 64'h00_00_01_01_01_00_00_00}  // R6 dow 7 to 1, R8 century 99
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regSel = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    regSel = a;
    #1;
    d = rdData;
  endtask

  task automatic readAccess(input logic [3:0] a);
    @(negedge clk);
    regSel = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Tick for one rising edge; returns at the falling edge right after it.
  task automatic tickOnce();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failCnt++;
    totalCnt++;
    $display("FAIL watchdog (all requirements) actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 12; i++) begin
      logic [7:0] e;
      e = (i == 3 || i == 4 || i == 5) ? 8'h01 : (i == 7) ? 8'h20 : 8'h00;
      peek(4'(i), v);
      check($sformatf("R1 reset reg %0d", i), v, e);
    end
    check("R1 reset alarmFlag", {7'd0, alarmFlag}, 8'h00);
    check("R1 reset alarmIntN", {7'd0, alarmIntN}, 8'h01);
    check("R1 reset strobes", {5'd0, secStrobe, minStrobe, hourStrobe}, 8'h00);

    // Vector table walk
    for (int n = 0; n < NVEC; n++) begin
      for (int f = 0; f < 8; f++) writeReg(4'(f), VECS[n].pre[f*8 +: 8]);
      tickOnce();
      for (int f = 0; f < 8; f++) begin
        peek(4'(f), v);
        check($sformatf("R%0d vector %0d field %0d", VECS[n].req, n, f), v, VECS[n].exp[f*8 +: 8]);
      end
    end

    // R2 write masking and unused addresses
    writeReg(4'd0, 8'hFF); peek(4'd0, v); check("R2 seconds mask", v, 8'h7F);
    writeReg(4'd3, 8'hFF); peek(4'd3, v); check("R2 dow mask", v, 8'h07);
    writeReg(4'd4, 8'hFF); peek(4'd4, v); check("R2 date mask", v, 8'h3F);
    writeReg(4'd5, 8'hFF); peek(4'd5, v); check("R2 month mask", v, 8'h1F);
    writeReg(4'd12, 8'hFF); peek(4'd12, v); check("R2 address 12 reads zero", v, 8'h00);
    peek(4'd15, v); check("R2 address 15 reads zero", v, 8'h00);

    // R9 strobes: 05:59:59 -> 06:00:00
    writeReg(4'd3, 8'h01); writeReg(4'd4, 8'h01); writeReg(4'd5, 8'h01);
    writeReg(4'd2, 8'h05); writeReg(4'd1, 8'h59); writeReg(4'd0, 8'h59);
    tickOnce();
    check("R9 strobes on hour roll", {5'd0, secStrobe, minStrobe, hourStrobe}, 8'h07);
    peek(4'd2, v); check("R9 hour visible with strobe", v, 8'h06);
    @(negedge clk);
    check("R9 strobes one cycle", {5'd0, secStrobe, minStrobe, hourStrobe}, 8'h00);
    writeReg(4'd0, 8'h10);
    tickOnce();
    check("R9 seconds-only strobe", {5'd0, secStrobe, minStrobe, hourStrobe}, 8'h04);

    // R10 seconds match, other fields masked
    writeReg(4'd8, 8'h05); writeReg(4'd9, 8'h80); writeReg(4'd10, 8'h80); writeReg(4'd11, 8'h80);
    writeReg(4'd0, 8'h04);
    tickOnce();
    check("R10 flag not yet set", {7'd0, alarmFlag}, 8'h00);
    @(negedge clk);
    check("R10 seconds match sets flag", {7'd0, alarmFlag}, 8'h01);
    check("R12 interrupt low with select 00", {7'd0, alarmIntN}, 8'h00);
    intervalSel = 2'b01; #1;
    check("R12 interrupt high with select 01", {7'd0, alarmIntN}, 8'h01);
    intervalSel = 2'b00;
    peek(4'd8, v); @(negedge clk);
    check("R11 peek without rdEn keeps flag", {7'd0, alarmFlag}, 8'h01);
    readAccess(4'd0);
    check("R11 read of time reg keeps flag", {7'd0, alarmFlag}, 8'h01);
    readAccess(4'd8);
    check("R11 alarm read clears flag", {7'd0, alarmFlag}, 8'h00);
    check("R12 interrupt released", {7'd0, alarmIntN}, 8'h01);
    tickOnce(); @(negedge clk);
    check("R10 seconds mismatch no flag", {7'd0, alarmFlag}, 8'h00);

    // R10 minutes and seconds match
    writeReg(4'd9, 8'h10); writeReg(4'd8, 8'h00);
    writeReg(4'd1, 8'h08); writeReg(4'd0, 8'h59);
    tickOnce(); @(negedge clk);
    check("R10 minute mismatch no flag", {7'd0, alarmFlag}, 8'h00);
    writeReg(4'd1, 8'h09); writeReg(4'd0, 8'h59);
    tickOnce(); @(negedge clk);
    check("R10 minute and second match", {7'd0, alarmFlag}, 8'h01);
    writeReg(4'd10, 8'h80);
    check("R11 alarm write clears flag", {7'd0, alarmFlag}, 8'h00);

    // R10 every-second alarm with all masks set
    writeReg(4'd8, 8'h80); writeReg(4'd9, 8'h80);
    tickOnce(); @(negedge clk);
    check("R10 all masked fires", {7'd0, alarmFlag}, 8'h01);
    writeReg(4'd11, 8'hFF);
    peek(4'd11, v); check("R2 alarm dow mask", v, 8'h87);
    check("R11 dow alarm write clears flag", {7'd0, alarmFlag}, 8'h00);

    summary();
    $finish;
  end
endmodule